// File: doc/BRIEF.md
# Read Request Credit Tracker

This block sits between an endpoint's application logic and its transaction layer and issues memory reads toward the host. It gives each accepted read a free tag and forwards it. A read is accepted only if the receive space set aside for completions can absorb the worst case that read could cost. Each read is at most 512 bytes, starts on a 64-byte boundary, and is given a whole-request reservation of 8 header credits and 32 data credits when it is issued.

The host may split a reply only at 64-byte aligned boundaries. Replies for one tag come back in rising address order, but replies for different tags may interleave. The block keeps one beat pointer per tag and writes every payload beat into that tag's own 512-byte region of a reassembly RAM. When a tag has received all its bytes, the block pulses that tag's done bit and frees the tag. Credits flow back as data arrives: one data credit per 16-byte beat and one header credit per completion. Any part of the reservation that was not used is handed back when the request finishes.

Top module: `rdcred_tracker`

## Requirements
- R1: After reset, `req_ready` is 1 and `rd_issue`, `ram_we` and `done_pulse` are all 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. One cycle later, `rd_issue` pulses for one cycle carrying the lowest-numbered free tag and the request's address and length unchanged.
- R3: Each accepted request takes 8 header and 32 data credits. `req_ready` is low whenever fewer than 8 header or fewer than 32 data credits are available. With the default pool of 28/112, a fourth outstanding request is stalled and produces no `rd_issue`.
- R4: Each accepted beat returns 1 data credit. A beat with `cpl_last` set returns 1 header credit. The beat that completes a request returns the request's unused header and data reservation instead, so over its lifetime every request returns exactly 8 header and 32 data credits.
- R5: Each accepted beat is written to the RAM one cycle later with `ram_wdata` equal to `cpl_data`. The write address is `ram_addr = tag*32 + n`, where n counts, from 0, the beats already received for that tag since it was issued.
- R6: When beats of different tags interleave, each tag's beat count advances only on its own beats.
- R7: A request of length L bytes (a multiple of 16, from 16 to 512) finishes on its (L/16)-th beat. One cycle after that beat, `done_pulse[tag]` is high for one cycle and the tag becomes free and can be reissued.
- R8: A beat whose `cpl_tag` is not outstanding is ignored. It produces no RAM write and no done pulse.
- R9: When every tag is outstanding, `req_ready` is low even if credits remain.
- R10: The available header and data credits never exceed their reserved amounts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | ADDR_W | Request byte address (64-byte aligned) |
| req_len | input | LEN_W | Request length in bytes, a multiple of 16, 16..512 |
| rd_issue | output | 1 | Read issued to the transaction layer |
| rd_tag | output | TAG_W | Tag of the issued read |
| rd_addr | output | ADDR_W | Address of the issued read |
| rd_len | output | LEN_W | Length of the issued read |
| cpl_valid | input | 1 | Completion payload beat valid |
| cpl_tag | input | TAG_W | Tag the beat belongs to |
| cpl_data | input | DATA_W | 16-byte payload beat |
| cpl_last | input | 1 | Last beat of one completion |
| ram_we | output | 1 | Reassembly RAM write enable |
| ram_addr | output | TAG_W+5 | RAM beat address: tag region and offset |
| ram_wdata | output | DATA_W | RAM write data |
| done_pulse | output | NUM_TAGS | One-cycle pulse per tag on request completion |

## Verification
Beat patterns are played in three shapes: one request split into many 64-byte completions, one request answered by a single long completion, and two tags whose beats alternate. Together these separate per-completion header return from end-of-request remainder return, and show whether the tag pointers are shared or independent. Reads are issued until the credit pool runs out, and again after the pool has been refilled. Requesting once more after everything has drained would expose any leaked credit as a stall. A second instance with only two tags shows the stall caused by running out of tags rather than credits, and a beat aimed at an idle tag checks that stray data is dropped.

// File: rtl/rdcred_pkg.sv
package rdcred_pkg;
  // bytes covered by one data credit; one payload beat carries exactly this much
  localparam int unsigned DCREDIT_BYTES = 16;

  // ceiling log2 with a floor of one bit, for index widths
  function automatic int unsigned clog2_min1(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((32'd1 << r) < v) r++;
    return (r == 0) ? 1 : r;
  endfunction
endpackage

// File: rtl/rdcred_credit_pool.sv
module rdcred_credit_pool #(
  parameter int unsigned RESERVE  = 28,
  parameter int unsigned TAKE_AMT = 8,
  localparam int unsigned W = $clog2(RESERVE + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic [W-1:0] give,
  output logic [W-1:0] avail,
  output logic         enough
);
  logic [W-1:0] avail_q, avail_d;

  always_comb begin
    avail_d = avail_q + give - (take ? W'(TAKE_AMT) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) avail_q <= W'(RESERVE);
    else        avail_q <= avail_d;
  end

  assign avail  = avail_q;
  assign enough = (avail_q >= W'(TAKE_AMT));
endmodule

// File: rtl/rdcred_tag_pick.sv
module rdcred_tag_pick #(
  parameter int unsigned NUM_TAGS = 4,
  localparam int unsigned TAG_W = rdcred_pkg::clog2_min1(NUM_TAGS)
) (
  input  logic [NUM_TAGS-1:0] busy,
  output logic                any_free,
  output logic [TAG_W-1:0]    pick_idx,
  output logic [NUM_TAGS-1:0] pick_oh
);
  // scan downward so the lowest free tag is the one left standing
  always_comb begin
    any_free = 1'b0;
    pick_idx = '0;
    pick_oh  = '0;
    for (int i = NUM_TAGS - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        any_free = 1'b1;
        pick_idx = TAG_W'(i);
        pick_oh  = NUM_TAGS'(1) << i;
      end
    end
  end
endmodule

// File: rtl/rdcred_tag_track.sv
module rdcred_tag_track #(
  parameter int unsigned NUM_TAGS = 4,
  parameter int unsigned HDR_WC   = 8,
  parameter int unsigned DATA_WC  = 32,
  localparam int unsigned TAG_W = rdcred_pkg::clog2_min1(NUM_TAGS),
  localparam int unsigned LB_W  = $clog2(DATA_WC + 1),
  localparam int unsigned HW    = $clog2(HDR_WC + 1),
  localparam int unsigned OFF_W = $clog2(DATA_WC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TAGS-1:0] alloc_oh,
  input  logic [LB_W-1:0]     alloc_beats,
  input  logic                cpl_valid,
  input  logic [TAG_W-1:0]    cpl_tag,
  input  logic                cpl_last,
  output logic [NUM_TAGS-1:0] busy,
  output logic                hit,
  output logic [OFF_W-1:0]    hit_off,
  output logic [NUM_TAGS-1:0] fin_oh,
  output logic [HW-1:0]       hdr_give,
  output logic [LB_W-1:0]     data_give
);
  logic [NUM_TAGS-1:0] sel_v;
  logic [LB_W-1:0]     rx_v [NUM_TAGS];
  logic [HW-1:0]       hs_v [NUM_TAGS];

  for (genvar g = 0; g < NUM_TAGS; g++) begin : g_tag
    logic            busy_q, busy_d;
    logic [LB_W-1:0] len_q, len_d, rx_q, rx_d;
    logic [HW-1:0]   hs_q, hs_d;
    logic            sel;

    assign sel       = cpl_valid && busy_q && (cpl_tag == TAG_W'(g));
    assign fin_oh[g] = sel && ((rx_q + LB_W'(1)) == len_q);
    assign busy[g]   = busy_q;
    assign sel_v[g]  = sel;
    assign rx_v[g]   = rx_q;
    assign hs_v[g]   = hs_q;

    always_comb begin
      busy_d = busy_q;
      len_d  = len_q;
      rx_d   = rx_q;
      hs_d   = hs_q;
      if (alloc_oh[g]) begin
        busy_d = 1'b1;
        len_d  = alloc_beats;
        rx_d   = '0;
        hs_d   = '0;
      end else if (sel) begin
        rx_d = rx_q + LB_W'(1);
        if (cpl_last) hs_d = hs_q + HW'(1);
        if (fin_oh[g]) busy_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q <= 1'b0;
        len_q  <= '0;
        rx_q   <= '0;
        hs_q   <= '0;
      end else begin
        busy_q <= busy_d;
        len_q  <= len_d;
        rx_q   <= rx_d;
        hs_q   <= hs_d;
      end
    end
  end

  // at most one tag is selected per beat; return credits for it
  always_comb begin
    hit       = 1'b0;
    hit_off   = '0;
    hdr_give  = '0;
    data_give = '0;
    for (int i = 0; i < NUM_TAGS; i++) begin
      if (sel_v[i]) begin
        hit     = 1'b1;
        hit_off = rx_v[i][OFF_W-1:0];
        if (fin_oh[i]) begin
          hdr_give  = HW'(HDR_WC) - hs_v[i];
          data_give = LB_W'(DATA_WC) - rx_v[i];
        end else begin
          hdr_give  = cpl_last ? HW'(1) : '0;
          data_give = LB_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/rdcred_tracker.sv
module rdcred_tracker
  import rdcred_pkg::*;
#(
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned DATA_W        = 128,
  parameter int unsigned NUM_TAGS      = 4,
  parameter int unsigned MAX_REQ_BYTES = 512,
  parameter int unsigned RCB_BYTES     = 64,
  parameter int unsigned HDR_RESERVE   = 28,
  parameter int unsigned DATA_RESERVE  = 112,
  localparam int unsigned TAG_W   = clog2_min1(NUM_TAGS),
  localparam int unsigned LEN_W   = $clog2(MAX_REQ_BYTES) + 1,
  localparam int unsigned HDR_WC  = MAX_REQ_BYTES / RCB_BYTES,
  localparam int unsigned DATA_WC = MAX_REQ_BYTES / DCREDIT_BYTES,
  localparam int unsigned OFF_W   = $clog2(DATA_WC),
  localparam int unsigned RAM_AW  = TAG_W + OFF_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [LEN_W-1:0]    req_len,
  output logic                rd_issue,
  output logic [TAG_W-1:0]    rd_tag,
  output logic [ADDR_W-1:0]   rd_addr,
  output logic [LEN_W-1:0]    rd_len,
  input  logic                cpl_valid,
  input  logic [TAG_W-1:0]    cpl_tag,
  input  logic [DATA_W-1:0]   cpl_data,
  input  logic                cpl_last,
  output logic                ram_we,
  output logic [RAM_AW-1:0]   ram_addr,
  output logic [DATA_W-1:0]   ram_wdata,
  output logic [NUM_TAGS-1:0] done_pulse
);
  localparam int unsigned LB_W  = $clog2(DATA_WC + 1);
  localparam int unsigned HW    = $clog2(HDR_WC + 1);
  localparam int unsigned HC_W  = $clog2(HDR_RESERVE + 1);
  localparam int unsigned DC_W  = $clog2(DATA_RESERVE + 1);
  localparam int unsigned LSH   = $clog2(DCREDIT_BYTES);

  logic [NUM_TAGS-1:0] tag_busy, pick_oh, fin_oh, alloc_oh;
  logic [TAG_W-1:0]    pick_idx;
  logic                any_free, hdr_ok, data_ok, accept, cpl_hit;
  logic [HC_W-1:0]     hdr_avail;
  logic [DC_W-1:0]     data_avail;
  logic [HW-1:0]       hdr_give;
  logic [LB_W-1:0]     data_give;
  logic [OFF_W-1:0]    hit_off;

  assign req_ready = hdr_ok && data_ok && any_free;
  assign accept    = req_valid && req_ready;
  assign alloc_oh  = accept ? pick_oh : '0;

  rdcred_credit_pool #(.RESERVE(HDR_RESERVE), .TAKE_AMT(HDR_WC)) u_hdr_pool (
    .clk(clk), .rst_n(rst_n), .take(accept), .give(HC_W'(hdr_give)),
    .avail(hdr_avail), .enough(hdr_ok)
  );

  rdcred_credit_pool #(.RESERVE(DATA_RESERVE), .TAKE_AMT(DATA_WC)) u_data_pool (
    .clk(clk), .rst_n(rst_n), .take(accept), .give(DC_W'(data_give)),
    .avail(data_avail), .enough(data_ok)
  );

  rdcred_tag_pick #(.NUM_TAGS(NUM_TAGS)) u_pick (
    .busy(tag_busy), .any_free(any_free), .pick_idx(pick_idx), .pick_oh(pick_oh)
  );

  rdcred_tag_track #(.NUM_TAGS(NUM_TAGS), .HDR_WC(HDR_WC), .DATA_WC(DATA_WC)) u_track (
    .clk(clk), .rst_n(rst_n), .alloc_oh(alloc_oh),
    .alloc_beats(LB_W'(req_len >> LSH)),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_last(cpl_last),
    .busy(tag_busy), .hit(cpl_hit), .hit_off(hit_off), .fin_oh(fin_oh),
    .hdr_give(hdr_give), .data_give(data_give)
  );

  // output stage: next-state then registers
  logic                issue_d, we_d;
  logic [TAG_W-1:0]    tag_d;
  logic [ADDR_W-1:0]   addr_d;
  logic [LEN_W-1:0]    len_d;
  logic [RAM_AW-1:0]   waddr_d;
  logic [DATA_W-1:0]   wdata_d;

  always_comb begin
    issue_d = accept;
    tag_d   = accept ? pick_idx : rd_tag;
    addr_d  = accept ? req_addr : rd_addr;
    len_d   = accept ? req_len  : rd_len;
    we_d    = cpl_hit;
    waddr_d = cpl_hit ? {cpl_tag, hit_off} : ram_addr;
    wdata_d = cpl_hit ? cpl_data : ram_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_issue   <= 1'b0;
      rd_tag     <= '0;
      rd_addr    <= '0;
      rd_len     <= '0;
      ram_we     <= 1'b0;
      ram_addr   <= '0;
      ram_wdata  <= '0;
      done_pulse <= '0;
    end else begin
      rd_issue   <= issue_d;
      rd_tag     <= tag_d;
      rd_addr    <= addr_d;
      rd_len     <= len_d;
      ram_we     <= we_d;
      ram_addr   <= waddr_d;
      ram_wdata  <= wdata_d;
      done_pulse <= fin_oh;
    end
  end
endmodule

// File: rtl/rdcred_chk.sv
module rdcred_chk #(
  parameter int unsigned NUM_TAGS     = 4,
  parameter int unsigned TAG_W        = 2,
  parameter int unsigned HC_W         = 5,
  parameter int unsigned DC_W         = 7,
  parameter int unsigned HDR_RESERVE  = 28,
  parameter int unsigned DATA_RESERVE = 112,
  parameter int unsigned HDR_WC       = 8,
  parameter int unsigned DATA_WC      = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic                rd_issue,
  input logic [TAG_W-1:0]    rd_tag,
  input logic                cpl_valid,
  input logic                ram_we,
  input logic [NUM_TAGS-1:0] done_pulse,
  input logic [NUM_TAGS-1:0] tag_busy,
  input logic [HC_W-1:0]     hdr_avail,
  input logic [DC_W-1:0]     data_avail
);
  // R10
  hdr_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_avail <= HC_W'(HDR_RESERVE));
  // R10
  data_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_avail <= DC_W'(DATA_RESERVE));
  // R3
  credit_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_avail < HC_W'(HDR_WC) || data_avail < DC_W'(DATA_WC)) |-> !req_ready);
  // R3
  outstanding_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tag_busy) <= (HDR_RESERVE / HDR_WC));
  // R2
  issue_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (rd_issue && tag_busy[rd_tag]));
  // R7
  done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_pulse));
  // R7
  done_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse != '0) |-> ((done_pulse & tag_busy) == '0));
  // R8
  write_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(cpl_valid));
endmodule

bind rdcred_tracker rdcred_chk #(
  .NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W), .HC_W(HC_W), .DC_W(DC_W),
  .HDR_RESERVE(HDR_RESERVE), .DATA_RESERVE(DATA_RESERVE),
  .HDR_WC(HDR_WC), .DATA_WC(DATA_WC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rd_issue(rd_issue), .rd_tag(rd_tag), .cpl_valid(cpl_valid), .ram_we(ram_we),
  .done_pulse(done_pulse), .tag_busy(tag_busy),
  .hdr_avail(hdr_avail), .data_avail(data_avail)
);

// File: tb/sim_rdcred_tracker.sv
`timescale 1ns/1ps
module sim_rdcred_tracker;
  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic         req_valid, req_ready, rd_issue, cpl_valid, cpl_last, ram_we;
  logic [31:0]  req_addr, rd_addr;
  logic [9:0]   req_len, rd_len;
  logic [1:0]   rd_tag, cpl_tag;
  logic [127:0] cpl_data, ram_wdata;
  logic [6:0]   ram_addr;
  logic [3:0]   done_pulse;

  rdcred_tracker u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .rd_issue(rd_issue), .rd_tag(rd_tag),
    .rd_addr(rd_addr), .rd_len(rd_len), .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
    .cpl_data(cpl_data), .cpl_last(cpl_last), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .done_pulse(done_pulse)
  );

  // two-tag instance for the tag-exhaustion case
  logic         r1_valid, r1_ready, r1_issue, r1_we, r1_tag;
  logic [31:0]  r1_addr, r1_raddr;
  logic [9:0]   r1_len, r1_rlen;
  logic [5:0]   r1_waddr;
  logic [127:0] r1_wdata;
  logic [1:0]   r1_done;

  rdcred_tracker #(.NUM_TAGS(2)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(r1_valid), .req_ready(r1_ready),
    .req_addr(r1_addr), .req_len(r1_len), .rd_issue(r1_issue), .rd_tag(r1_tag),
    .rd_addr(r1_raddr), .rd_len(r1_rlen), .cpl_valid(1'b0), .cpl_tag(1'b0),
    .cpl_data('0), .cpl_last(1'b0), .ram_we(r1_we), .ram_addr(r1_waddr),
    .ram_wdata(r1_wdata), .done_pulse(r1_done)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int m_ptr [4];
  int m_len [4];
  bit m_busy [4];
  int beat_no = 0;

  // interleaved beats for tags 0 and 1: {tag[1:0], last}
  localparam logic [2:0] BEAT_TBL [12] = '{
    3'b000, 3'b010, 3'b000, 3'b010, 3'b000, 3'b010,
    3'b001, 3'b011, 3'b000, 3'b000, 3'b000, 3'b001
  };

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic [9:0] l,
                       input bit ok, input int tag, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = l;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req, "rd_issue", 128'(rd_issue), 128'(ok));
    if (ok) begin
      chk(req, "rd_tag", 128'(rd_tag), 128'(tag));
      chk(req, "rd_addr", 128'(rd_addr), 128'(a));
      chk(req, "rd_len", 128'(rd_len), 128'(l));
      m_busy[tag] = 1; m_len[tag] = int'(l) / 16; m_ptr[tag] = 0;
    end
  endtask

  task automatic beat(input int tag, input bit last, input string req);
    logic [127:0] d;
    bit fin;
    d = {96'h0, 32'hC0DE_0000 + 32'(beat_no)};
    beat_no++;
    @(negedge clk);
    cpl_valid = 1'b1; cpl_tag = 2'(tag); cpl_data = d; cpl_last = last;
    @(negedge clk);
    cpl_valid = 1'b0; cpl_last = 1'b0;
    chk(req, "ram_we", 128'(ram_we), 128'(m_busy[tag]));
    fin = 0;
    if (m_busy[tag]) begin
      chk(req, "ram_addr", 128'(ram_addr), 128'(tag * 32 + m_ptr[tag]));
      chk(req, "ram_wdata", ram_wdata, d);
      m_ptr[tag]++;
      if (m_ptr[tag] == m_len[tag]) begin fin = 1; m_busy[tag] = 0; end
    end
    chk(req, "done_pulse", 128'(done_pulse), fin ? 128'(1) << tag : 128'(0));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_addr = '0; req_len = '0;
    cpl_valid = 0; cpl_tag = '0; cpl_data = '0; cpl_last = 0;
    r1_valid = 0; r1_addr = '0; r1_len = '0;
    for (int i = 0; i < 4; i++) begin m_ptr[i] = 0; m_len[i] = 0; m_busy[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "req_ready", 128'(req_ready), 128'(1));
    chk("R1", "rd_issue", 128'(rd_issue), 128'(0));
    chk("R1", "ram_we", 128'(ram_we), 128'(0));
    chk("R1", "done_pulse", 128'(done_pulse), 128'(0));

    // R2 issue with lowest free tags
    issue(32'h0000_1000, 10'd128, 1, 0, "R2");
    issue(32'h0000_2040, 10'd64,  1, 1, "R2");
    issue(32'h0000_3000, 10'd512, 1, 2, "R2");
    // R3 pool exhausted after three reads
    chk("R3", "req_ready", 128'(req_ready), 128'(0));
    issue(32'h0000_4000, 10'd64, 0, 0, "R3");

    // R4 per-completion return: three 64-byte completions leave 7/28
    for (int c = 0; c < 3; c++)
      for (int b = 0; b < 4; b++) beat(2, b == 3, "R4");
    chk("R4", "req_ready after 3 cpl", 128'(req_ready), 128'(0));
    for (int b = 0; b < 4; b++) beat(2, b == 3, "R4");
    chk("R4", "req_ready after 4 cpl", 128'(req_ready), 128'(1));

    // R5 R6 R7 interleaved table
    for (int i = 0; i < 12; i++)
      beat(int'(BEAT_TBL[i][2:1]), BEAT_TBL[i][0], "R6");

    // R7 freed tag 0 is reused
    issue(32'h0000_5000, 10'd256, 1, 0, "R7");
    // R7 R5 tag 2 finishes with one long completion
    for (int b = 0; b < 16; b++) beat(2, b == 15, "R7");

    // R4 no leak: exactly two more reads fit, then stall again
    issue(32'h0000_6000, 10'd512, 1, 1, "R4");
    issue(32'h0000_7000, 10'd16,  1, 2, "R4");
    chk("R4", "req_ready refilled pool", 128'(req_ready), 128'(0));

    // R8 beat to idle tag 3
    beat(3, 1, "R8");

    // R9 tag exhaustion on the two-tag instance
    @(negedge clk);
    r1_valid = 1'b1; r1_addr = 32'h0000_8000; r1_len = 10'd64;
    @(negedge clk);
    chk("R9", "first issue", 128'(r1_issue), 128'(1));
    chk("R9", "first tag", 128'(r1_tag), 128'(0));
    @(negedge clk);
    chk("R9", "second tag", 128'(r1_tag), 128'(1));
    chk("R9", "ready with no tag", 128'(r1_ready), 128'(0));
    @(negedge clk);
    r1_valid = 1'b0;
    chk("R9", "no third issue", 128'(r1_issue), 128'(0));

    repeat (2) @(negedge clk);
    summary();
  end
endmodule